// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts scanlines and raises a line interrupt once every programmable number of lines. The video timing generator gives it a one-cycle strobe for each new scanline and the number of that line. The host loads a reload value into a configuration register. An enable bit decides whether a pending line interrupt reaches the interrupt request output.

The counter steps down on each scanline of the active picture and on the one line that follows it. On every other line it is loaded again from the reload register. When it steps below zero it takes the reload value again and marks a line interrupt as pending. The pending mark stays set until the host reads status. The interrupt request merges the enabled line interrupt with the frame interrupt that comes in from outside the block.

Top module: `line_irq_counter`

## Requirements
- R1: After reset, `line_pending` and `irq` are 0 (with `frame_irq` at 0), and both the count and the reload register hold 0xFF.
- R2: A strobe on a line numbered 0 to 192 inclusive (`ACTIVE_LINES`) decrements a nonzero count by one.
- R3: A strobe on any line numbered above 192 loads the count from the reload register and never sets the pending flag.
- R4: A strobe on a window line while the count is 0x00 loads the count from the reload register and sets `line_pending` in the next cycle. With reload value N, the first pending line after a window starts from a fresh load is line N, and pending lines then repeat every N+1 lines.
- R5: A write to the reload register leaves the running count unchanged. The new value is used only at the next load, whether that load comes from underflow or from an out-of-window line.
- R6: A one-cycle `status_rd` pulse clears `line_pending` in the next cycle.
- R7: `irq` is 1 exactly when `frame_irq` is 1, or when `line_pending` and `line_irq_en` are both 1.
- R8: If an underflow and a status read happen in the same cycle, the pending flag ends up set.
- R9: With no line strobe, the count holds its value, whatever the number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse at the start of each scanline |
| line_num | input | 9 | Number of the scanline being started |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_data | input | 8 | Value written to the reload register |
| line_irq_en | input | 1 | Line interrupt enable |
| status_rd | input | 1 | Host status read; clears the pending flag |
| frame_irq | input | 1 | Frame interrupt from elsewhere, merged into `irq` |
| line_pending | output | 1 | Line interrupt pending flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `line_stb` is a single-cycle pulse and that `line_num` is valid whenever the strobe is high. They also assume that a reload write never falls in the same cycle as a strobe. The stimulus respects all three: each strobe is followed by at least one idle cycle, and writes and extra status reads are placed only in idle cycles. The one exception is the deliberate test where a strobe and a status read share a cycle. The sweep walks through whole 262-line frames for a set of reload values that includes 0, 1, the window edges and 255. Long idle gaps are inserted so that the hold behaviour shows up in the timing of later underflows.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    // What the counter does on a given cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_LOAD = 2'd2
    } step_e;

    // Decoded per-cycle control for the counter
    typedef struct packed {
        step_e step;
        logic  in_window;
    } line_ctl_t;

    // Window membership: lines 0 .. last_dec inclusive count down
    function automatic logic line_in_window(input logic [8:0] num,
                                            input logic [8:0] last_dec);
        return num <= last_dec;
    endfunction

    function automatic step_e pick_step(input logic stb, input logic in_win);
        if (!stb)
            return STEP_HOLD;
        else if (in_win)
            return STEP_DEC;
        else
            return STEP_LOAD;
    endfunction

endpackage

// File: rtl/lirq_window.sv
module lirq_window
    import lirq_pkg::*;
#(
    parameter int LINE_W       = 9,
    parameter int ACTIVE_LINES = 192
) (
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    output line_ctl_t         ctl
);
    localparam logic [8:0] LAST_DEC = 9'(ACTIVE_LINES);

    logic [8:0] num_ext;
    logic       in_win;

    generate
        if (LINE_W >= 9) begin : g_trunc
            assign num_ext = line_num[8:0];
        end else begin : g_pad
            assign num_ext = {{(9-LINE_W){1'b0}}, line_num};
        end
    endgenerate

    always_comb begin
        in_win        = line_in_window(num_ext, LAST_DEC);
        ctl.in_window = in_win;
        ctl.step      = pick_step(line_stb, in_win);
    end
endmodule

// File: rtl/lirq_reload_reg.sv
module lirq_reload_reg #(
    parameter int          CNT_W     = 8,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_VAL);

    always_ff @(posedge clk) begin
        if (rst)
            value <= RST_V;
        else if (wr)
            value <= wdata;
    end
endmodule

// File: rtl/lirq_counter.sv
module lirq_counter
    import lirq_pkg::*;
#(
    parameter int          CNT_W     = 8,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             uflow
);
    localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_VAL);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             at_zero;
    logic [CNT_W-1:0] count_nx;

    always_comb begin
        at_zero  = (count == '0);
        uflow    = (step == STEP_DEC) && at_zero;
        count_nx = count;
        unique case (step)
            STEP_DEC:  count_nx = at_zero ? reload_val : count - ONE;
            STEP_LOAD: count_nx = reload_val;
            default:   count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= RST_V;
        else
            count <= count_nx;
    end
endmodule

// File: rtl/lirq_pending.sv
module lirq_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // set has priority so an underflow is never lost to a read
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter
    import lirq_pkg::*;
#(
    parameter int         LINE_W       = 9,
    parameter int         CNT_W        = 8,
    parameter int         ACTIVE_LINES = 192,
    parameter logic [7:0] RELOAD_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              reload_wr,
    input  logic [CNT_W-1:0]  reload_data,
    input  logic              line_irq_en,
    input  logic              status_rd,
    input  logic              frame_irq,
    output logic              line_pending,
    output logic              irq
);
    line_ctl_t        ctl;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count;
    logic             uflow;

    lirq_window #(
        .LINE_W      (LINE_W),
        .ACTIVE_LINES(ACTIVE_LINES)
    ) u_window (
        .line_stb(line_stb),
        .line_num(line_num),
        .ctl     (ctl)
    );

    lirq_reload_reg #(
        .CNT_W    (CNT_W),
        .RESET_VAL(RELOAD_RESET)
    ) u_reload (
        .clk  (clk),
        .rst  (rst),
        .wr   (reload_wr),
        .wdata(reload_data),
        .value(reload_q)
    );

    lirq_counter #(
        .CNT_W    (CNT_W),
        .RESET_VAL(RELOAD_RESET)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .step      (ctl.step),
        .reload_val(reload_q),
        .count     (count),
        .uflow     (uflow)
    );

    lirq_pending u_pending (
        .clk (clk),
        .rst (rst),
        .set (uflow),
        .clr (status_rd),
        .flag(line_pending)
    );

    assign irq = (line_pending && line_irq_en) || frame_irq;
endmodule

// File: rtl/line_irq_counter_chk.sv
module line_irq_counter_chk #(
    parameter int LINE_W       = 9,
    parameter int CNT_W        = 8,
    parameter int ACTIVE_LINES = 192
) (
    input logic              clk,
    input logic              rst,
    input logic              line_stb,
    input logic [LINE_W-1:0] line_num,
    input logic              reload_wr,
    input logic              status_rd,
    input logic              line_pending,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload_q,
    input logic              uflow
);
    localparam int LAST = ACTIVE_LINES;

    logic in_win;
    assign in_win = (int'(line_num) <= LAST);

    // R1: pending is clear on the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> !line_pending);

    // R2: a nonzero count steps down by one in the window
    a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
        (line_stb && in_win && count != '0) |=> (count == $past(count) - 1'b1));

    // R3: outside the window the count takes the reload value, no interrupt
    a_r3_force_load: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !in_win && !reload_wr) |=> (count == $past(reload_q)));

    a_r3_no_uflow_outside: assert property (@(posedge clk) disable iff (rst)
        (line_stb && !in_win) |-> !uflow);

    // R4: underflow reloads and sets pending
    a_r4_uflow_reload: assert property (@(posedge clk) disable iff (rst)
        (uflow && !reload_wr) |=> (count == $past(reload_q)));

    a_r4_uflow_sets: assert property (@(posedge clk) disable iff (rst)
        uflow |=> line_pending);

    a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(line_pending) |-> $past(uflow));

    // R6: a read with no underflow clears pending
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !uflow) |=> !line_pending);

    // R9: no strobe, no change in count
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !line_stb |=> $stable(count));
endmodule

bind line_irq_counter line_irq_counter_chk #(
    .LINE_W      (LINE_W),
    .CNT_W       (CNT_W),
    .ACTIVE_LINES(ACTIVE_LINES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_stb    (line_stb),
    .line_num    (line_num),
    .reload_wr   (reload_wr),
    .status_rd   (status_rd),
    .line_pending(line_pending),
    .count       (count),
    .reload_q    (reload_q),
    .uflow       (uflow)
);

// File: tb/line_irq_counter_tb.sv
module line_irq_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic [8:0] line_num = '0;
    logic       reload_wr = 1'b0;
    logic [7:0] reload_data = '0;
    logic       line_irq_en = 1'b0;
    logic       status_rd = 1'b0;
    logic       frame_irq = 1'b0;
    logic       line_pending;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state, derived from the requirements
    int ref_cnt = 255;
    int ref_reg = 255;
    bit ref_pend = 0;

    always #10 clk = ~clk;

    line_irq_counter u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_stb    (line_stb),
        .line_num    (line_num),
        .reload_wr   (reload_wr),
        .reload_data (reload_data),
        .line_irq_en (line_irq_en),
        .status_rd   (status_rd),
        .frame_irq   (frame_irq),
        .line_pending(line_pending),
        .irq         (irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " pending"}, line_pending, ref_pend);
        check("R7 irq", irq, (ref_pend && line_irq_en) || frame_irq);
    endtask

    // one scanline strobe, optionally with a simultaneous status read
    task automatic do_line(input int l, input bit rd);
        bit uf;
        @(negedge clk);
        line_stb  = 1'b1;
        line_num  = 9'(l);
        status_rd = rd;
        @(negedge clk);
        line_stb  = 1'b0;
        status_rd = 1'b0;
        uf = 0;
        if (l <= 192) begin
            if (ref_cnt == 0) begin
                ref_cnt = ref_reg;
                uf = 1;
            end else begin
                ref_cnt = ref_cnt - 1;
            end
        end else begin
            ref_cnt = ref_reg;
        end
        if (rd) ref_pend = 0;
        if (uf) ref_pend = 1;     // R8: set wins over same-cycle read
        if (l <= 192) check(uf ? "R4" : "R2", line_pending, ref_pend);
        else          check("R3", line_pending, ref_pend);
        check("R7 irq", irq, (ref_pend && line_irq_en) || frame_irq);
    endtask

    task automatic status_read();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        ref_pend = 0;
        check_outputs("R6");
    endtask

    task automatic write_reload(input int v);
        @(negedge clk);
        reload_wr   = 1'b1;
        reload_data = 8'(v);
        @(negedge clk);
        reload_wr = 1'b0;
        ref_reg = v;       // R5: count untouched until next load
        check_outputs("R5");
    endtask

    task automatic run_frame(input int rd_every, input int idle_gap);
        for (int l = 0; l < 262; l++) begin
            do_line(l, 1'b0);
            if (rd_every > 0 && (l % rd_every) == 0 && ref_pend) status_read();
            if (idle_gap > 0 && l == 40) repeat (idle_gap) @(negedge clk); // R9
        end
    endtask

    initial begin
        int vals[10] = '{0, 1, 2, 5, 63, 191, 192, 193, 255, 7};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        line_irq_en = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pending", line_pending, 1'b0);
        check("R1 irq", irq, 1'b0);

        // frame from reset values: count 0xFF never underflows in window
        run_frame(0, 0);

        for (int i = 0; i < 10; i++) begin
            // written at frame start: running count keeps the old load (R5)
            write_reload(vals[i]);
            line_irq_en = i[0];
            run_frame(0, 0);
            line_irq_en = ~i[0];
            run_frame(3, 25);
        end

        // R5: write in the middle of the window while counting down
        write_reload(30);
        run_frame(0, 0);
        for (int l = 0; l < 10; l++) do_line(l, 1'b0);
        write_reload(3);
        for (int l = 10; l < 262; l++) do_line(l, 1'b0);
        run_frame(0, 0);

        // R8: underflow and status read in one cycle
        write_reload(0);
        run_frame(0, 0);
        line_irq_en = 1'b1;
        do_line(0, 1'b0);
        do_line(1, 1'b1);
        check("R8 set wins", line_pending, 1'b1);
        status_read();

        // R7: frame interrupt passes regardless of enable
        line_irq_en = 1'b0;
        @(negedge clk);
        frame_irq = 1'b1;
        @(negedge clk);
        check("R7 frame", irq, 1'b1);
        frame_irq = 1'b0;
        @(negedge clk);
        check("R7 frame off", irq, 1'b0);

        // R1: reset mid-run restores defaults (count 0xFF, reload 0xFF)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_pend = 0; ref_cnt = 255; ref_reg = 255;
        check_outputs("R1");
        run_frame(0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule